// File: doc/BRIEF.md
# System-Management Mode State Save/Restore Sequencer

This block moves a 32-bit processor model into and out of a system-management mode. On an entry request it writes every piece of held architectural state to a save area in memory. The state covers the control registers, the flags, the instruction pointer, the general and debug registers, the selectors, the descriptor-table caches and the segment caches. It writes one 32-bit word per accepted transfer, then installs a fixed entry state. On a resume request it reads the same words back from the same addresses and restores them.

It also owns the mode flag, the NMI-blocking flag and the NMI-nesting flag. It holds the relocatable save base, which is reloaded on resume only when the stored revision word advertises relocation. The core model loads and reads the held state through a word-indexed port.

The memory side is a single port with a request and a ready handshake. The sequencer holds each word until ready is seen.

Top module: `smm_seq_top`

## Requirements
- R1: After a synchronous active-low reset the block is idle (`busy`=0, `mem_req`=0, `done`=0), all three flags are clear and `smbase_out` is 0x00030000.
- R2: An entry request starts a save only when the block is idle and not in the mode. A resume request starts a restore only when the block is idle and in the mode. Any other request is ignored, and `mem_req` stays low.
- R3: Transfer n (n = 0..52) uses address `smbase_out` + 0x8000 + offset(n), and transfers go in increasing n. Slot n is also state index n on the core port. The offsets are:
  - n = 0..15: 0x7ffc − 4n. This covers CR0, CR3, EFLAGS, EIP, then EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX, then DR6, DR7, then the task selector and the local-table selector.
  - n = 16..21: segment selector i = n−16 at 0x7fa8 + 4i, in the order ES, CS, SS, DS, FS, GS.
  - n = 22..24: task base 0x7f64, limit 0x7f60, attribute 0x7f5c.
  - n = 25..27: local-table base 0x7f80, limit 0x7f7c, attribute 0x7f78.
  - n = 28..29: global-table base 0x7f74, limit 0x7f70.
  - n = 30..31: interrupt-table base 0x7f58, limit 0x7f54.
  - n = 32..49: segment k = (n−32)/3, with j = (n−32) mod 3 selecting attribute, limit, base. The address is P + 4j, where P = 0x7f84 + 12k for k < 3 and P = 0x7f2c + 12(k−3) otherwise.
  - n = 50: CR4 at 0x7f14.
  - n = 51: revision at 0x7efc.
  - n = 52: base at 0x7ef8.
- R4: Attribute slots (n = 24, 27, 32 + 3k) are saved as (value >> 8) & 0xf0ff and restored as (word & 0xf0ff) << 8. Selector slots (n = 14..21) are restored as word & 0xffff.
- R5: While `mem_ready` is low during a transfer, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R6: A save writes the revision constant 0x00020000 at slot 51 and the current base at slot 52. After it:
  - EIP = 0x00008000, DR7 = 0x00000400, CR4 = 0;
  - CR0 loses bits 0, 2, 3 and 31;
  - CS selector = (base >> 4) & 0xffff and CS base = base;
  - the other five selectors and bases are 0;
  - all six limits are 0xffffffff.
- R7: When a save completes, the mode flag is set. If NMIs were already blocked the nesting flag is set; otherwise the blocking flag is set.
- R8: A restore loads slots 0..50 from memory. When it completes, NMI blocking is cleared only if the nesting flag was clear, and then the nesting and mode flags are cleared.
- R9: On restore the base is loaded from slot 52 only when bit 17 of the word read at slot 51 is 1. Otherwise it is unchanged.
- R10: `done` is high for exactly one cycle, the cycle after the last transfer is accepted, with the new state already visible. `busy` is high from the cycle after a request is accepted until that cycle.
- R11: Core-port writes (`core_we`, index < 51) and NMI-flag inputs take effect only while idle. While `busy` they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_req | input | 1 | Request to save state and enter the mode |
| resume_req | input | 1 | Request to restore state and leave the mode |
| nmi_block_set | input | 1 | Core accepted an NMI; set blocking (idle only) |
| nmi_block_clr | input | 1 | Core finished NMI handling; clear blocking (idle only) |
| core_we | input | 1 | Write one held state word |
| core_idx | input | 6 | State index for writes |
| core_wdata | input | 32 | State word to write |
| core_ridx | input | 6 | State index for reads (52 returns the base) |
| core_rdata | output | 32 | Held state word at `core_ridx` |
| mem_req | output | 1 | Transfer pending |
| mem_we | output | 1 | 1 for save writes, 0 for restore reads |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Word written during a save |
| mem_rdata | input | 32 | Word read during a restore, taken when ready |
| mem_ready | input | 1 | Memory accepts the current transfer |
| busy | output | 1 | Save or restore in progress |
| done | output | 1 | One-cycle completion pulse |
| smm_active | output | 1 | Mode flag |
| nmi_blocked | output | 1 | NMI-blocking flag |
| nmi_inside | output | 1 | Mode entered while NMIs were blocked |
| smbase_out | output | 32 | Current save base |

## Verification
The assertions assume that `mem_rdata` is meaningful only in cycles where `mem_ready` is high with a read pending. They also assume that the memory eventually raises `mem_ready`, and that request pulses are single cycles driven between clock edges. The stimulus follows these rules:
- a memory model in the bench answers reads from what it stored;
- ready follows a fixed irregular pattern, so every transfer completes after a few stalls;
- requests and core writes are changed only at the falling edge.

Core writes during a restore and requests in the wrong mode are issued on purpose, inside those same timing rules.

// File: rtl/smm_pkg.sv
// Package: shared widths, slot indices and the save-area slot map.
// Assumes a 32-bit save layout; every slot is one 32-bit word.
package smm_pkg;
    localparam int unsigned XLEN     = 32;
    localparam int unsigned NSLOT    = 53;
    localparam int unsigned NSTATE   = 51;
    localparam int unsigned IDXW     = $clog2(NSLOT);
    localparam int unsigned NSEG     = 6;
    localparam int unsigned SEG_CS   = 1;
    localparam int unsigned S_CR0    = 0;
    localparam int unsigned S_EIP    = 3;
    localparam int unsigned S_DR7    = 13;
    localparam int unsigned S_SEGSEL = 16;
    localparam int unsigned S_SEGDSC = 32;
    localparam int unsigned S_CR4    = 50;
    localparam int unsigned S_REV    = 51;
    localparam int unsigned S_BASE   = 52;
    localparam logic [XLEN-1:0] REV_ID     = 32'h0002_0000;
    localparam logic [XLEN-1:0] RST_BASE   = 32'h0003_0000;
    localparam logic [XLEN-1:0] AREA_OFS   = 32'h0000_8000;
    localparam logic [XLEN-1:0] ENTRY_IP   = 32'h0000_8000;
    localparam logic [XLEN-1:0] ENTRY_DR7  = 32'h0000_0400;
    localparam logic [XLEN-1:0] CR0_CLRMSK = 32'h8000_000d;

    typedef enum logic [2:0] {K_WORD, K_SEL, K_ATTR, K_REV, K_BASE} slot_kind_e;

    typedef struct packed {
        logic [15:0] off;
        slot_kind_e  kind;
    } slot_t;

    // Computes the offset and kind of save slot n.
    function automatic slot_t slot_of(input int unsigned n);
        slot_t s;
        int unsigned k, j, p;
        s.kind = K_WORD;
        s.off  = 16'h0;
        if (n < 16) begin
            s.off = 16'(32'h7ffc - 4 * n);
            if (n >= 14) s.kind = K_SEL;
        end else if (n < 22) begin
            s.off = 16'(32'h7fa8 + 4 * (n - 16));
            s.kind = K_SEL;
        end else if (n < 25) begin
            s.off = 16'(32'h7f64 - 4 * (n - 22));
            if (n == 24) s.kind = K_ATTR;
        end else if (n < 28) begin
            s.off = 16'(32'h7f80 - 4 * (n - 25));
            if (n == 27) s.kind = K_ATTR;
        end else if (n < 30) begin
            s.off = 16'(32'h7f74 - 4 * (n - 28));
        end else if (n < 32) begin
            s.off = 16'(32'h7f58 - 4 * (n - 30));
        end else if (n < 50) begin
            k = (n - 32) / 3;
            j = (n - 32) % 3;
            p = (k < 3) ? (32'h7f84 + 12 * k) : (32'h7f2c + 12 * (k - 3));
            s.off = 16'(p + 4 * j);
            if (j == 0) s.kind = K_ATTR;
        end else if (n == 50) begin
            s.off = 16'h7f14;
        end else if (n == 51) begin
            s.off = 16'h7efc;
            s.kind = K_REV;
        end else begin
            s.off = 16'h7ef8;
            s.kind = K_BASE;
        end
        return s;
    endfunction
endpackage

// File: rtl/smm_addr_gen.sv
// Address generator: turns the slot index and save base into a byte address and slot kind.
// Assumes idx < NSLOT while a transfer is pending.
module smm_addr_gen
    import smm_pkg::*;
(
    input  logic [IDXW-1:0] idx,
    input  logic [XLEN-1:0] base,
    output logic [XLEN-1:0] addr,
    output slot_kind_e      kind
);
    slot_t slot;

    // Looks up the slot and adds the area offset to the base.
    always_comb begin
        slot = slot_of(int'(idx));
        kind = slot.kind;
        addr = base + AREA_OFS + {16'h0, slot.off};
    end
endmodule

// File: rtl/smm_seq_ctrl.sv
// Sequencer control: walks slots 0..NSLOT-1 one word per accepted handshake.
// Assumes at most one start pulse per cycle; starts are taken only while idle.
module smm_seq_ctrl
    import smm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_save,
    input  logic            start_load,
    input  logic            mem_ready,
    output logic            busy,
    output logic            dir_save,
    output logic [IDXW-1:0] idx,
    output logic            hs,
    output logic            last_hs,
    output logic            done
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NSLOT - 1);

    assign hs      = busy && mem_ready;
    assign last_hs = hs && (idx == LAST);

    // Holds the run state, direction, slot counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            dir_save <= 1'b0;
            idx      <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start_save || start_load) begin
                    busy     <= 1'b1;
                    dir_save <= start_save;
                    idx      <= '0;
                end
            end else if (mem_ready) begin
                if (idx == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> (busy && $stable(idx) && $stable(dir_save)))
        else $error("stalled slot moved");
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");
    p_done_after_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy))
        else $error("done without a finished run");
endmodule

// File: rtl/smm_state_file.sv
// State file: holds the saved words, the base and the NMI/mode flags.
// Applies restore words, the entry state and the flag rules.
// Assumes hs/last_hs come from smm_seq_ctrl and idx addresses the current slot.
module smm_state_file
    import smm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            dir_save,
    input  logic            hs,
    input  logic            last_hs,
    input  logic [IDXW-1:0] idx,
    input  slot_kind_e      kind,
    input  logic [XLEN-1:0] rdata,
    input  logic            core_we,
    input  logic [IDXW-1:0] core_idx,
    input  logic [XLEN-1:0] core_wdata,
    input  logic [IDXW-1:0] core_ridx,
    input  logic            nmi_set,
    input  logic            nmi_clr,
    output logic [XLEN-1:0] core_rdata,
    output logic [XLEN-1:0] save_word,
    output logic [XLEN-1:0] smbase,
    output logic            smm_on,
    output logic            nmi_blk,
    output logic            nmi_in
);
    logic [XLEN-1:0] st [NSTATE];
    logic            rev_ok;
    logic [XLEN-1:0] cur;

    // Picks the held word of the current slot.
    always_comb cur = (int'(idx) < NSTATE) ? st[idx] : '0;

    // Encodes the outgoing word for the current slot kind.
    always_comb begin
        unique case (kind)
            K_ATTR:  save_word = {16'h0, cur[23:8] & 16'hf0ff};
            K_REV:   save_word = REV_ID;
            K_BASE:  save_word = smbase;
            default: save_word = cur;
        endcase
    end

    // Core-side read port; index S_BASE returns the base.
    always_comb begin
        if (int'(core_ridx) < NSTATE) core_rdata = st[core_ridx];
        else if (int'(core_ridx) == S_BASE) core_rdata = smbase;
        else core_rdata = '0;
    end

    // Updates the state words, the base and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTATE; i++) st[i] <= '0;
            smbase  <= RST_BASE;
            smm_on  <= 1'b0;
            nmi_blk <= 1'b0;
            nmi_in  <= 1'b0;
            rev_ok  <= 1'b0;
        end else begin
            if (!busy) begin
                if (core_we && int'(core_idx) < NSTATE) st[core_idx] <= core_wdata;
                if (nmi_set) nmi_blk <= 1'b1;
                else if (nmi_clr) nmi_blk <= 1'b0;
            end
            if (hs && !dir_save) begin
                unique case (kind)
                    K_REV:   rev_ok <= rdata[17];
                    K_BASE:  if (rev_ok) smbase <= rdata;
                    K_SEL:   st[idx] <= rdata & 32'h0000_ffff;
                    K_ATTR:  st[idx] <= (rdata & 32'h0000_f0ff) << 8;
                    default: st[idx] <= rdata;
                endcase
            end
            if (last_hs && dir_save) begin
                st[S_EIP] <= ENTRY_IP;
                st[S_DR7] <= ENTRY_DR7;
                st[S_CR4] <= '0;
                st[S_CR0] <= st[S_CR0] & ~CR0_CLRMSK;
                for (int k = 0; k < NSEG; k++) begin
                    st[S_SEGSEL + k]       <= (k == SEG_CS) ? {16'h0, smbase[19:4]} : '0;
                    st[S_SEGDSC + 3*k + 1] <= '1;
                    st[S_SEGDSC + 3*k + 2] <= (k == SEG_CS) ? smbase : '0;
                end
                smm_on <= 1'b1;
                if (nmi_blk) nmi_in <= 1'b1;
                else nmi_blk <= 1'b1;
            end
            if (last_hs && !dir_save) begin
                if (!nmi_in) nmi_blk <= 1'b0;
                nmi_in <= 1'b0;
                smm_on <= 1'b0;
            end
        end
    end

    p_base_moves_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(smbase) |-> ($past(last_hs) && !$past(dir_save)))
        else $error("base changed outside a restore end");
    p_entry_blocks_nmi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smm_on) |-> nmi_blk)
        else $error("mode entered with NMIs unblocked");
    p_resume_clears_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smm_on) |-> !nmi_in)
        else $error("nesting flag left set after resume");
endmodule

// File: rtl/smm_seq_top.sv
// Top: gates requests by mode, wires the sequencer, address generator and state file.
// Assumes the memory answers every transfer eventually; rdata is used only with ready.
module smm_seq_top
    import smm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter_req,
    input  logic        resume_req,
    input  logic        nmi_block_set,
    input  logic        nmi_block_clr,
    input  logic        core_we,
    input  logic [5:0]  core_idx,
    input  logic [31:0] core_wdata,
    input  logic [5:0]  core_ridx,
    output logic [31:0] core_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        busy,
    output logic        done,
    output logic        smm_active,
    output logic        nmi_blocked,
    output logic        nmi_inside,
    output logic [31:0] smbase_out
);
    logic            start_save, start_load, dir_save, hs, last_hs;
    logic [IDXW-1:0] idx;
    slot_kind_e      kind;

    assign start_save = enter_req  && !busy && !smm_active;
    assign start_load = resume_req && !busy &&  smm_active;
    assign mem_req    = busy;
    assign mem_we     = dir_save;

    smm_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_save(start_save), .start_load(start_load),
        .mem_ready(mem_ready), .busy(busy), .dir_save(dir_save), .idx(idx),
        .hs(hs), .last_hs(last_hs), .done(done)
    );

    smm_addr_gen u_addr (
        .idx(idx), .base(smbase_out), .addr(mem_addr), .kind(kind)
    );

    smm_state_file u_state (
        .clk(clk), .rst_n(rst_n), .busy(busy), .dir_save(dir_save), .hs(hs),
        .last_hs(last_hs), .idx(idx), .kind(kind), .rdata(mem_rdata),
        .core_we(core_we), .core_idx(core_idx), .core_wdata(core_wdata),
        .core_ridx(core_ridx), .nmi_set(nmi_block_set), .nmi_clr(nmi_block_clr),
        .core_rdata(core_rdata), .save_word(mem_wdata), .smbase(smbase_out),
        .smm_on(smm_active), .nmi_blk(nmi_blocked), .nmi_in(nmi_inside)
    );

    p_start_matches_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_we == !$past(smm_active)))
        else $error("run direction disagrees with mode");
    p_stall_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)))
        else $error("bus changed during stall");
endmodule

// File: tb/tb_smm_seq_top.sv
// Bench: behavioural reference (queues, arrays) compared with the bus every cycle.
module tb_smm_seq_top;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        enter_req = 0, resume_req = 0, nmi_block_set = 0, nmi_block_clr = 0;
    logic        core_we = 0;
    logic [5:0]  core_idx = 0, core_ridx = 0;
    logic [31:0] core_wdata = 0, core_rdata;
    logic        mem_req, mem_we, mem_ready = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        busy, done, smm_active, nmi_blocked, nmi_inside;
    logic [31:0] smbase_out;

    int checks = 0, fails = 0, tick = 0, cycles = 0;
    logic [31:0] ref_st [51];
    logic [31:0] ref_base;
    bit ref_smm, ref_blk, ref_in;
    logic [31:0] mem [int unsigned];
    logic [31:0] q_addr [$];
    bit          q_we [$];
    logic [31:0] q_data [$];
    bit inject_core_write = 0;

    smm_seq_top dut (.*);

    always #2 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned off_of(input int n);
        int k, j;
        if (n < 16) return 32'h7ffc - 4*n;
        if (n < 22) return 32'h7fa8 + 4*(n-16);
        if (n < 25) return 32'h7f64 - 4*(n-22);
        if (n < 28) return 32'h7f80 - 4*(n-25);
        if (n < 30) return 32'h7f74 - 4*(n-28);
        if (n < 32) return 32'h7f58 - 4*(n-30);
        if (n < 50) begin
            k = (n-32)/3; j = (n-32)%3;
            return ((k < 3) ? 32'h7f84 + 12*k : 32'h7f2c + 12*(k-3)) + 4*j;
        end
        if (n == 50) return 32'h7f14;
        if (n == 51) return 32'h7efc;
        return 32'h7ef8;
    endfunction

    function automatic bit is_attr(input int n);
        return n == 24 || n == 27 || (n >= 32 && n < 50 && (n-32)%3 == 0);
    endfunction

    function automatic logic [31:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Runs one save (sv=1) or restore and compares the bus against the queue each cycle.
    task automatic run_op(input bit sv);
        int unsigned a;
        @(negedge clk);
        for (int n = 0; n < 53; n++) begin
            q_addr.push_back(ref_base + 32'h8000 + off_of(n));
            q_we.push_back(sv);
            if (n < 51) q_data.push_back(is_attr(n) ? ((ref_st[n] >> 8) & 32'hf0ff) : ref_st[n]);
            else if (n == 51) q_data.push_back(32'h0002_0000);
            else q_data.push_back(ref_base);
        end
        if (sv) enter_req = 1; else resume_req = 1;
        @(negedge clk);
        enter_req = 0; resume_req = 0;
        while (!done) begin
            tick++;
            mem_ready = ((tick * 7) % 11) > 3;
            core_we = 0;
            if (inject_core_write && q_addr.size() == 3) begin
                core_we = 1; core_idx = 6'd3; core_wdata = 32'hdead_beef;
            end
            chk(busy, "R10", "busy during run", busy, 1);
            if (mem_req) begin
                if (q_addr.size() == 0) chk(0, "R3", "extra transfer", mem_addr, 0);
                else begin
                    chk(mem_addr == q_addr[0], "R3", "address", mem_addr, q_addr[0]);
                    chk(mem_we == q_we[0], "R3", "direction", mem_we, q_we[0]);
                    if (sv) chk(mem_wdata == q_data[0], "R4", "save word", mem_wdata, q_data[0]);
                    if (sv && mem_ready) mem[mem_addr] = mem_wdata;
                    if (!sv) mem_rdata = rd(mem_addr);
                    if (mem_ready) begin
                        void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_data.pop_front());
                    end
                end
            end
            @(negedge clk);
        end
        core_we = 0; mem_ready = 0;
        chk(q_addr.size() == 0, "R10", "done after last word", q_addr.size(), 0);
        // Apply the reference update for this operation.
        if (sv) begin
            ref_smm = 1;
            if (ref_blk) ref_in = 1; else ref_blk = 1;
            ref_st[3] = 32'h8000; ref_st[13] = 32'h400; ref_st[50] = 0;
            ref_st[0] &= ~32'h8000_000d;
            for (int k = 0; k < 6; k++) begin
                ref_st[16+k] = (k == 1) ? ((ref_base >> 4) & 32'hffff) : 0;
                ref_st[32+3*k+1] = 32'hffff_ffff;
                ref_st[32+3*k+2] = (k == 1) ? ref_base : 0;
            end
        end else begin
            for (int n = 0; n < 51; n++) begin
                a = ref_base + 32'h8000 + off_of(n);
                if (n >= 14 && n < 22) ref_st[n] = rd(a) & 32'hffff;
                else if (is_attr(n)) ref_st[n] = (rd(a) & 32'hf0ff) << 8;
                else ref_st[n] = rd(a);
            end
            if (rd(ref_base + 32'h8000 + 32'h7efc) & 32'h0002_0000)
                ref_base = rd(ref_base + 32'h8000 + 32'h7ef8);
            if (!ref_in) ref_blk = 0;
            ref_in = 0; ref_smm = 0;
        end
        @(negedge clk);
        chk(!done, "R10", "done single cycle", done, 0);
    endtask

    task automatic cmp_state(input string req);
        for (int n = 0; n < 51; n++) begin
            core_ridx = 6'(n); #1;
            chk(core_rdata == ref_st[n], req, $sformatf("state[%0d]", n), core_rdata, ref_st[n]);
        end
        chk(smbase_out == ref_base, "R9", "base", smbase_out, ref_base);
        chk(smm_active == ref_smm, req, "mode flag", smm_active, ref_smm);
        chk(nmi_blocked == ref_blk, "R7", "nmi blocked", nmi_blocked, ref_blk);
        chk(nmi_inside == ref_in, "R8", "nmi inside", nmi_inside, ref_in);
    endtask

    task automatic try_ignored(input bit ent, input string what);
        @(negedge clk);
        if (ent) enter_req = 1; else resume_req = 1;
        @(negedge clk);
        enter_req = 0; resume_req = 0;
        for (int c = 0; c < 3; c++) begin
            chk(!mem_req && !busy, "R2", what, mem_req, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        int unsigned b;
        ref_base = 32'h0003_0000; ref_smm = 0; ref_blk = 0; ref_in = 0;
        for (int n = 0; n < 51; n++) ref_st[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(!busy && !mem_req && !done, "R1", "idle after reset", {busy, mem_req, done}, 0);
        chk(smbase_out == 32'h0003_0000, "R1", "reset base", smbase_out, 32'h0003_0000);
        chk(!smm_active && !nmi_blocked && !nmi_inside, "R1", "flags clear",
            {smm_active, nmi_blocked, nmi_inside}, 0);
        // Load distinct state through the core port (R11 idle writes)
        for (int n = 0; n < 51; n++) begin
            core_we = 1; core_idx = 6'(n);
            core_wdata = 32'h1000_0000 * (n % 15) + 32'h0001_0203 * n + 32'h8000_000f;
            ref_st[n] = core_wdata;
            @(negedge clk);
        end
        core_we = 0;
        cmp_state("R11");
        try_ignored(0, "resume ignored outside mode");
        // Entry with NMIs open
        run_op(1);
        cmp_state("R6");
        try_ignored(1, "enter ignored in mode");
        // Alter the save area, then resume with a core write injected mid-run
        b = ref_base + 32'h8000;
        mem[b + 32'h7ff0] = 32'h0000_1234;
        mem[b + 32'h7fa8] = mem[b + 32'h7fa8] | 32'habcd_0000;
        mem[b + 32'h7f84] = mem[b + 32'h7f84] | 32'h0000_0f00;
        mem[b + 32'h7ef8] = 32'h0004_0000;
        inject_core_write = 1;
        run_op(0);
        inject_core_write = 0;
        cmp_state("R8");
        chk(smbase_out == 32'h0004_0000, "R9", "relocated base", smbase_out, 32'h0004_0000);
        // Nested entry: NMI already blocked
        @(negedge clk); nmi_block_set = 1; ref_blk = 1;
        @(negedge clk); nmi_block_set = 0;
        run_op(1);
        cmp_state("R7");
        chk(nmi_inside, "R7", "nesting flag set", nmi_inside, 1);
        // Clear the capability bit: base must not reload; blocking stays
        b = ref_base + 32'h8000;
        mem[b + 32'h7efc] = 32'h0000_0064;
        mem[b + 32'h7ef8] = 32'h0009_0000;
        run_op(0);
        cmp_state("R8");
        chk(smbase_out == 32'h0004_0000, "R9", "base kept without bit 17", smbase_out, 32'h0004_0000);
        chk(nmi_blocked, "R8", "blocking kept when nested", nmi_blocked, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule